// File: doc/BRIEF.md
# Address Match Trigger Unit

This block decides, every cycle, whether one of a small set of debug triggers should stop the hart. Each trigger is described by three configuration words: a control word, a compare address and a context qualifier word. The block checks them against what the hart is doing right now: the fetch PC, and an optional load or store access. It also takes the current privilege level, a flag that says whether the hart runs a guest, and the context register. When a configured trigger matches, it raises a breakpoint request. It also reports which trigger fired and the address that caused the hit.

Two trigger flavours are understood. They differ in how they treat guest execution. The older flavour is silent while a guest runs. The newer one has separate guest-user and guest-supervisor enables. Matching is by exact equality with the compare address. There is no mask or range matching, no chaining and no data-value comparison. The logic is purely combinational, so the request can stop the instruction or access before it completes.

Top module: `addr_trigger_unit`

## Requirements
- R1: The trigger flavour is read from control bits [XLEN-1:XLEN-4]. Only the value 2 (classic) and the value 6 (guest-aware) can hit. Any other flavour value never raises a request.
- R2: Outside guest mode, a trigger is privilege-qualified only when control bit 3+privLvl is set. The privilege encodings are user=0, supervisor=1 and machine=3. privLvl=2 never qualifies. The same rule holds for both flavours.
- R3: A classic (flavour 2) trigger never hits while virtEn is 1.
- R4: In guest mode, a flavour-6 trigger is qualified only by control bit 23+privLvl. Guest user is 0 and guest supervisor is 1. Any other privLvl never qualifies.
- R5: A trigger whose control word has no qualifying privilege bit, or has none of the load (bit 0), store (bit 1) and execute (bit 2) bits set, never hits.
- R6: An execute hit needs control bit 2 set and fetchPc equal to the compare address. badAddr then shows fetchPc.
- R7: A data hit needs lsValid=1 and an address equal to the compare address. A load has lsWrite=0 and needs bit 0. A store has lsWrite=1 and needs bit 1. badAddr then shows lsAddr.
- R8: The qualifier word holds a selector in bits [XLEN-CTX_W-1:XLEN-CTX_W-3] and a context value in bits [XLEN-1:XLEN-CTX_W]. When the selector is 4, the trigger also needs the context value to equal ctxVal. For any other selector, ctxVal is ignored.
- R9: When several triggers hit in one cycle, hitIdx names the lowest-numbered one, and badAddr follows that trigger.
- R10: When no trigger hits, brkReq, hitIdx and badAddr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| trigCtrl | input | NUM_TRIG*XLEN | Control words; trigger i occupies bits [i*XLEN +: XLEN] |
| trigAddr | input | NUM_TRIG*XLEN | Compare addresses, same packing |
| trigExtra | input | NUM_TRIG*XLEN | Context qualifier words, same packing |
| privLvl | input | 2 | Current privilege encoding |
| virtEn | input | 1 | Hart runs in a guest mode |
| ctxVal | input | CTX_W | Context register low bits |
| fetchPc | input | XLEN | PC of the instruction about to execute |
| lsValid | input | 1 | A load or store is presented this cycle |
| lsWrite | input | 1 | The presented access is a store |
| lsAddr | input | XLEN | Address of the presented access |
| brkReq | output | 1 | Breakpoint request |
| hitIdx | output | IDXW | Index of the winning trigger |
| badAddr | output | XLEN | Address that caused the hit |

## Verification
A single trigger is swept over four flavour values, all 32 combinations of its five privilege enables and all eight load/store/execute masks. Each setting is tried under every privilege level, with and without guest mode. This separates the privilege offsets of the two flavours, the silence of the classic flavour in guest mode, and the dead privLvl=2 encoding. Each setting is tried with five activity patterns: idle, fetch match, load match, store match, and a valid load to a different address. Together these show that the execute, load and store bits are each tied to the right activity, and that equality alone decides the hit. Separate cases toggle the qualifier selector and the context value to show when ctxVal matters, and make both triggers hit together so that the lower index wins.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;

  // flavour codes found in the top nibble of a control word
  localparam logic [3:0] FLAV_CLASSIC = 4'd2;
  localparam logic [3:0] FLAV_GUEST   = 4'd6;

  // control word bit positions
  localparam int LD_BIT     = 0;
  localparam int ST_BIT     = 1;
  localparam int EX_BIT     = 2;
  localparam int HOST_BASE  = 3;   // user/supervisor/machine enables at 3+priv
  localparam int GUEST_BASE = 23;  // guest user/supervisor enables at 23+priv

  // privilege encodings
  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;
  localparam logic [1:0] PRIV_RSVD  = 2'd2;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  // qualifier selector value that enables context comparison
  localparam logic [2:0] CTX_SEL_ON = 3'd4;

  // strobes handed from control to datapath
  typedef struct packed {
    logic hit;
    logic fromFetch;
  } trigSel_t;

endpackage

// File: rtl/trig_datapath.sv
`timescale 1ns/1ps
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NUM_TRIG = 2,
  parameter int XLEN     = 32,
  parameter int CTX_W    = 6
) (
  input  logic [NUM_TRIG*XLEN-1:0] trigAddr,
  input  logic [NUM_TRIG*XLEN-1:0] trigExtra,
  input  logic [CTX_W-1:0]         ctxVal,
  input  logic [XLEN-1:0]          fetchPc,
  input  logic [XLEN-1:0]          lsAddr,
  input  trigSel_t                 sel,
  output logic [NUM_TRIG-1:0]      pcEq,
  output logic [NUM_TRIG-1:0]      lsEq,
  output logic [NUM_TRIG-1:0]      ctxOk,
  output logic [XLEN-1:0]          badAddr
);

  localparam int CTX_HI = XLEN - 1;
  localparam int CTX_LO = XLEN - CTX_W;
  localparam int SEL_HI = CTX_LO - 1;
  localparam int SEL_LO = CTX_LO - 3;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : gTrig
    logic [XLEN-1:0]  cmpAddr;
    logic [XLEN-1:0]  extraWord;
    logic [2:0]       ctxSel;
    logic [CTX_W-1:0] ctxWant;

    assign cmpAddr   = trigAddr[g*XLEN +: XLEN];
    assign extraWord = trigExtra[g*XLEN +: XLEN];
    assign ctxSel    = extraWord[SEL_HI:SEL_LO];
    assign ctxWant   = extraWord[CTX_HI:CTX_LO];

    assign pcEq[g]  = (fetchPc == cmpAddr);
    assign lsEq[g]  = (lsAddr == cmpAddr);
    assign ctxOk[g] = (ctxSel != CTX_SEL_ON) || (ctxWant == ctxVal);
  end

  always_comb begin
    if (!sel.hit)          badAddr = '0;
    else if (sel.fromFetch) badAddr = fetchPc;
    else                    badAddr = lsAddr;
  end

endmodule

// File: rtl/trig_control.sv
`timescale 1ns/1ps
module trig_control
  import trig_pkg::*;
#(
  parameter int NUM_TRIG = 2,
  parameter int XLEN     = 32,
  parameter int IDXW     = 1
) (
  input  logic [NUM_TRIG*XLEN-1:0] trigCtrl,
  input  logic [1:0]               privLvl,
  input  logic                     virtEn,
  input  logic                     lsValid,
  input  logic                     lsWrite,
  input  logic [NUM_TRIG-1:0]      pcEq,
  input  logic [NUM_TRIG-1:0]      lsEq,
  input  logic [NUM_TRIG-1:0]      ctxOk,
  output trigSel_t                 sel,
  output logic [IDXW-1:0]          hitIdx
);

  logic [NUM_TRIG-1:0] trigHit;
  logic [NUM_TRIG-1:0] exHit;

  logic isLoad, isStore, hostPrivOk, guestPrivOk;
  assign isLoad      = lsValid && !lsWrite;
  assign isStore     = lsValid && lsWrite;
  assign hostPrivOk  = (privLvl != PRIV_RSVD);
  assign guestPrivOk = (privLvl == PRIV_USER) || (privLvl == PRIV_SUPER);

  for (genvar g = 0; g < NUM_TRIG; g++) begin : gTrig
    logic [XLEN-1:0] ctrlWord;
    logic [3:0]      flavour;
    logic            isClassic, isGuest;
    logic            hostBit, guestBit, privOk;
    logic            ldHit, stHit;

    assign ctrlWord  = trigCtrl[g*XLEN +: XLEN];
    assign flavour   = ctrlWord[XLEN-1 -: 4];
    assign isClassic = (flavour == FLAV_CLASSIC);
    assign isGuest   = (flavour == FLAV_GUEST);
    assign hostBit   = ctrlWord[HOST_BASE + int'(privLvl)];
    assign guestBit  = ctrlWord[GUEST_BASE + int'(privLvl)];

    always_comb begin
      if (virtEn)       privOk = isGuest && guestPrivOk && guestBit;
      else              privOk = (isClassic || isGuest) && hostPrivOk && hostBit;
    end

    assign exHit[g] = privOk && ctxOk[g] && ctrlWord[EX_BIT] && pcEq[g];
    assign ldHit    = isLoad  && ctrlWord[LD_BIT] && lsEq[g];
    assign stHit    = isStore && ctrlWord[ST_BIT] && lsEq[g];
    assign trigHit[g] = exHit[g] || (privOk && ctxOk[g] && (ldHit || stHit));
  end

  // lowest index wins
  always_comb begin
    sel    = '0;
    hitIdx = '0;
    for (int i = NUM_TRIG - 1; i >= 0; i--) begin
      if (trigHit[i]) begin
        sel.hit       = 1'b1;
        sel.fromFetch = exHit[i];
        hitIdx        = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/addr_trigger_unit.sv
`timescale 1ns/1ps
module addr_trigger_unit
  import trig_pkg::*;
#(
  parameter  int NUM_TRIG = 2,
  parameter  int XLEN     = 32,
  parameter  int CTX_W    = 6,
  localparam int IDXW     = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic [NUM_TRIG*XLEN-1:0] trigCtrl,
  input  logic [NUM_TRIG*XLEN-1:0] trigAddr,
  input  logic [NUM_TRIG*XLEN-1:0] trigExtra,
  input  logic [1:0]               privLvl,
  input  logic                     virtEn,
  input  logic [CTX_W-1:0]         ctxVal,
  input  logic [XLEN-1:0]          fetchPc,
  input  logic                     lsValid,
  input  logic                     lsWrite,
  input  logic [XLEN-1:0]          lsAddr,
  output logic                     brkReq,
  output logic [IDXW-1:0]          hitIdx,
  output logic [XLEN-1:0]          badAddr
);

  trigSel_t            sel;
  logic [NUM_TRIG-1:0] pcEq, lsEq, ctxOk;

  trig_control #(.NUM_TRIG(NUM_TRIG), .XLEN(XLEN), .IDXW(IDXW)) uCtl (
    .trigCtrl(trigCtrl), .privLvl(privLvl), .virtEn(virtEn),
    .lsValid(lsValid), .lsWrite(lsWrite),
    .pcEq(pcEq), .lsEq(lsEq), .ctxOk(ctxOk),
    .sel(sel), .hitIdx(hitIdx)
  );

  trig_datapath #(.NUM_TRIG(NUM_TRIG), .XLEN(XLEN), .CTX_W(CTX_W)) uDp (
    .trigAddr(trigAddr), .trigExtra(trigExtra), .ctxVal(ctxVal),
    .fetchPc(fetchPc), .lsAddr(lsAddr), .sel(sel),
    .pcEq(pcEq), .lsEq(lsEq), .ctxOk(ctxOk), .badAddr(badAddr)
  );

  assign brkReq = sel.hit;

endmodule

// File: rtl/trig_unit_checker.sv
`timescale 1ns/1ps
module trig_unit_checker #(
  parameter int NUM_TRIG = 2,
  parameter int XLEN     = 32,
  parameter int IDXW     = 1
) (
  input logic [NUM_TRIG*XLEN-1:0] trigCtrl,
  input logic [NUM_TRIG*XLEN-1:0] trigAddr,
  input logic                     virtEn,
  input logic [XLEN-1:0]          fetchPc,
  input logic                     lsValid,
  input logic [XLEN-1:0]          lsAddr,
  input logic                     brkReq,
  input logic [IDXW-1:0]          hitIdx,
  input logic [XLEN-1:0]          badAddr
);

  logic [XLEN-1:0] winCtrl, winAddr;
  logic [3:0]      winFlav;

  always_comb begin
    winCtrl = trigCtrl[int'(hitIdx)*XLEN +: XLEN];
    winAddr = trigAddr[int'(hitIdx)*XLEN +: XLEN];
    winFlav = winCtrl[XLEN-1 -: 4];
    if (!brkReq) begin
      p_idle_quiet_r10: assert (hitIdx == '0 && badAddr == '0);
    end else begin
      p_known_flavour_r1: assert (winFlav == 4'd2 || winFlav == 4'd6);
      p_classic_guest_r3: assert (!(virtEn && winFlav == 4'd2));
      p_has_kind_r5: assert (winCtrl[2:0] != 3'b000);
      p_addr_equal_r6: assert (badAddr == winAddr);
      p_data_valid_r7: assert (badAddr == fetchPc || (lsValid && badAddr == lsAddr));
    end
  end

endmodule

bind addr_trigger_unit trig_unit_checker #(
  .NUM_TRIG(NUM_TRIG), .XLEN(XLEN), .IDXW(IDXW)
) uChk (
  .trigCtrl(trigCtrl), .trigAddr(trigAddr), .virtEn(virtEn),
  .fetchPc(fetchPc), .lsValid(lsValid), .lsAddr(lsAddr),
  .brkReq(brkReq), .hitIdx(hitIdx), .badAddr(badAddr)
);

// File: tb/sim_addr_trigger_unit.sv
`timescale 1ns/1ps
module sim_addr_trigger_unit;

  localparam int N = 2;
  localparam int X = 32;
  localparam int C = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [N*X-1:0] trigCtrl, trigAddr, trigExtra;
  logic [1:0]     privLvl;
  logic           virtEn;
  logic [C-1:0]   ctxVal;
  logic [X-1:0]   fetchPc, lsAddr;
  logic           lsValid, lsWrite;
  logic           brkReq;
  logic [0:0]     hitIdx;
  logic [X-1:0]   badAddr;

  addr_trigger_unit #(.NUM_TRIG(N), .XLEN(X), .CTX_W(C)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(string tag, logic eReq, logic [0:0] eIdx, logic [X-1:0] eAddr);
    checks++;
    if (brkReq !== eReq || hitIdx !== eIdx || badAddr !== eAddr) begin
      errors++;
      $display("FAIL %s: got req=%0b idx=%0d addr=%h, expected req=%0b idx=%0d addr=%h",
               tag, brkReq, hitIdx, badAddr, eReq, eIdx, eAddr);
    end
  endtask

  // privilege qualification from R1..R4
  function automatic logic privGate(logic [X-1:0] c, logic [1:0] p, logic v);
    logic [3:0] f = c[31:28];
    if (f != 4'd2 && f != 4'd6) return 1'b0;          // R1
    if (v) return (f == 4'd6) && (p < 2) && c[23 + p]; // R3, R4
    return (p != 2'd2) && c[3 + p];                    // R2
  endfunction

  function automatic logic [X-1:0] mkCtrl(logic [3:0] f, logic [4:0] m, logic [2:0] k);
    logic [X-1:0] c = '0;
    c[31:28] = f;
    c[2:0]   = k;
    c[3] = m[0]; c[4] = m[1]; c[6] = m[2]; c[23] = m[3]; c[24] = m[4];
    c[5] = 1'b1; c[25] = 1'b1; // bits that privLvl=2 would point at
    return c;
  endfunction

  task automatic apply();
    @(posedge clk);
    #1;
    @(negedge clk);
  endtask

  initial begin
    logic [3:0] flavs [4] = '{4'd0, 4'd2, 4'd5, 4'd6};
    logic [X-1:0] a0 = 32'h8000_1240;
    logic [X-1:0] a1 = 32'h8000_2a00;
    trigCtrl = '0; trigAddr = '0; trigExtra = '0; privLvl = 0; virtEn = 0;
    ctxVal = 0; fetchPc = 0; lsAddr = 0; lsValid = 0; lsWrite = 0;
    apply();
    // R10: everything at zero gives a quiet output
    check("R10", 1'b0, 1'b0, '0);

    // sweep of one trigger: R1 R2 R3 R4 R5 R6 R7
    trigAddr = {a1, a0};
    for (int fi = 0; fi < 4; fi++)
      for (int m = 0; m < 32; m++)
        for (int k = 0; k < 8; k++)
          for (int p = 0; p < 4; p++)
            for (int v = 0; v < 2; v++)
              for (int ac = 0; ac < 5; ac++) begin
                logic [X-1:0] c;
                logic g, e;
                logic [X-1:0] ea;
                string tag;
                c = mkCtrl(flavs[fi], m[4:0], k[2:0]);
                trigCtrl = {32'h0, c};
                privLvl = p[1:0]; virtEn = v[0];
                fetchPc = a0 + 4; lsAddr = a0 + 8; lsValid = 0; lsWrite = 0;
                case (ac)
                  1: fetchPc = a0;
                  2: begin lsValid = 1; lsAddr = a0; end
                  3: begin lsValid = 1; lsWrite = 1; lsAddr = a0; end
                  4: lsValid = 1;
                  default: ;
                endcase
                g = privGate(c, p[1:0], v[0]);
                e = 1'b0; ea = '0;
                if (g && ac == 1 && c[2]) begin e = 1; ea = a0; end           // R6
                if (g && ac == 2 && c[0]) begin e = 1; ea = a0; end           // R7
                if (g && ac == 3 && c[1]) begin e = 1; ea = a0; end           // R7
                if (ac == 1) tag = "R6 exec";
                else if (ac == 0 || ac == 4) tag = "R5 no-match";
                else tag = "R7 data";
                if (v && flavs[fi] == 4'd2) tag = "R3 classic-guest";
                else if (v) tag = {tag, " R4"};
                else tag = {tag, " R2"};
                if (flavs[fi] != 4'd2 && flavs[fi] != 4'd6) tag = "R1 flavour";
                apply();
                check(tag, e, 1'b0, ea);
              end

    // R8: context qualifier
    trigCtrl = {32'h0, mkCtrl(4'd2, 5'b00111, 3'b100)};
    privLvl = 3; virtEn = 0; fetchPc = a0; lsValid = 0;
    for (int s = 0; s < 8; s++)
      for (int cv = 0; cv < 4; cv++) begin
        logic [X-1:0] ex = '0;
        ex[31:26] = 6'd21;
        ex[25:23] = s[2:0];
        trigExtra = {32'h0, ex};
        ctxVal = (cv == 0) ? 6'd21 : 6'(cv * 13);
        apply();
        check("R8 context", (s != 4) || (ctxVal == 6'd21), 1'b0,
              ((s != 4) || (ctxVal == 6'd21)) ? a0 : '0);
      end
    trigExtra = '0;

    // R9: priority between two triggers
    trigAddr = {a0, a0};
    trigCtrl = {mkCtrl(4'd6, 5'b11111, 3'b111), mkCtrl(4'd2, 5'b00111, 3'b111)};
    privLvl = 1; virtEn = 0; fetchPc = a0; lsValid = 0;
    apply(); check("R9 both hit", 1'b1, 1'b0, a0);
    virtEn = 1;  // classic one silenced, guest-aware one remains
    apply(); check("R9 upper only", 1'b1, 1'b1, a0);
    virtEn = 0; trigAddr = {a0, a1}; fetchPc = a1 + 4; lsValid = 1; lsAddr = a0; lsWrite = 1;
    apply(); check("R9 store on upper", 1'b1, 1'b1, a0);
    lsAddr = a1;
    apply(); check("R9 store on lower", 1'b1, 1'b0, a1);
    lsValid = 0;
    apply(); check("R10 idle", 1'b0, 1'b0, '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule